// File: doc/BRIEF.md
# Dispatch and In-Order Retire Controller

This block sits between an in-order queue of decoded instructions and the out-of-order scheduler. In each cycle it looks at up to `W` instructions, oldest first. Each instruction carries a micro-op count, a count of destination registers and an operation kind. The block admits the longest prefix of these instructions that fits every resource: the dispatch width, the reorder-buffer entries, the free physical registers used for renaming, and the free space reported that cycle by the scheduler and by the load and store queues. Every instruction it admits is given a reorder-buffer tag.

The execution side reports finished instructions by tag. The reorder buffer retires finished instructions strictly in program order, up to `W` per cycle. Retirement returns the instruction's reorder-buffer entries and physical registers to their pools.

Each cycle in which dispatch stops at a blocked instruction is charged to exactly one stall cause. Two histograms are kept. One counts the cycles by the number of micro-ops dispatched. The other counts the cycles by the number of instructions retired.

Top module: `dispatch_retire_ctl`

## Requirements
- R1: Instructions are admitted as a contiguous prefix of the lanes, lane 0 being the oldest. An invalid lane or a blocked instruction stops every younger lane that cycle, even a younger lane that would fit.
- R2: An instruction joins the group only if the group's micro-op total, including the new instruction, stays at or below `W`. Legal micro-op counts are 1 to `W`. A stop caused by the width limit is not charged to any stall cause.
- R3: An instruction takes as many reorder-buffer entries as it has micro-ops. It is admitted only if that many entries are free, counting the entries already taken by older instructions in the same group.
- R4: An instruction is admitted only if the free physical registers cover its destination count plus the destinations of older instructions in the same group. When `PREGS` is 0, the register pool is unlimited and never blocks.
- R5: Every micro-op needs one entry of `sched_space`. An instruction of kind 1 (load) also needs one entry of `lq_space`, and an instruction of kind 2 (store) needs one entry of `sq_space`. Kinds 0 and 3 need neither. Each space input is the number of entries free in that cycle.
- R6: A write-back tag marks its instruction finished. From the next cycle on, finished instructions retire from the oldest entry, up to `W` per cycle. A finished instruction waits for every older instruction to finish. `ret_tag` lane j shows the tag of the j-th oldest instruction.
- R7: Retirement returns the instruction's reorder-buffer entries and destination registers to their pools. The returned resources can be used for dispatch starting the cycle after the retirement.
- R8: In each cycle that dispatch stops at a valid instruction that fits the width, exactly one stall counter is incremented. The cause is chosen in this priority order: registers (field 0), reorder-buffer entries (field 1), scheduler (field 2), load queue (field 3), store queue (field 4). Field k occupies `stall_cnt[k*CW +: CW]`.
- R9: In every cycle, bin k of `disp_hist` is incremented when k micro-ops are dispatched, and bin k of `ret_hist` is incremented when k instructions retire. Bin k occupies bits `[k*CW +: CW]`.
- R10: Reset clears every counter and empties the reorder buffer. After reset, all entries and registers are free and no retire lane is valid.
- R11: Dispatch tags are consecutive modulo `ROB_ENTRIES`. Lane j gets the tail index plus j, and the first instruction after reset gets tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | W | Instruction present, per lane |
| in_uops | input | W*UW | Micro-op count, per lane |
| in_ndst | input | W*DW | Destination register count, per lane |
| in_kind | input | 2*W | Operation kind, per lane (0 ALU, 1 load, 2 store) |
| sched_space | input | SPW | Free scheduler entries this cycle |
| lq_space | input | SPW | Free load queue entries this cycle |
| sq_space | input | SPW | Free store queue entries this cycle |
| disp_valid | output | W | Lane admitted this cycle |
| disp_tag | output | W*TW | Reorder-buffer tag, per lane |
| wb_valid | input | W | Completion report, per lane |
| wb_tag | input | W*TW | Tag of the completed instruction |
| ret_valid | output | W | Instruction retired, per lane, oldest in lane 0 |
| ret_tag | output | W*TW | Tag of the retiring instruction |
| disp_hist | output | (W+1)*CW | Histogram of micro-ops dispatched per cycle |
| ret_hist | output | (W+1)*CW | Histogram of instructions retired per cycle |
| stall_cnt | output | 5*CW | Stall cycles, one counter per cause |

## Verification
The hardest case to reach is a young instruction that has finished and is waiting while the register pool is drained and an older instruction is still outstanding. In that case retirement must hold back, and the blocked dispatch must keep charging the register cause. It must not charge a lower-priority cause that is also present. The stimulus builds this state as follows. It dispatches two instructions that use the whole register pool. It then offers a third instruction while cutting scheduler space to zero. Next it completes the younger instruction first and the older one a cycle later. The checks then expect retirement to be withheld, then a two-wide retirement, and dispatch to resume only on the following cycle. Similar sequences fill the reorder buffer to its last entry and pit the unlimited-pool variant against the limited one.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int NUM_CAUSES = 5;

  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_REG   = 3'd1,
    CAUSE_TOK   = 3'd2,
    CAUSE_SCHED = 3'd3,
    CAUSE_LQ    = 3'd4,
    CAUSE_SQ    = 3'd5
  } stall_cause_e;
endpackage

// File: rtl/dispatch_select.sv
module dispatch_select
  import disp_pkg::*;
#(
  parameter int W     = 2,
  parameter int UW    = 2,
  parameter int DW    = 2,
  parameter int SPW   = 4,
  parameter int FW    = 6,
  parameter bit UNLIM = 1'b0
) (
  input  logic [W-1:0]    in_valid,
  input  logic [W*UW-1:0] in_uops,
  input  logic [W*DW-1:0] in_ndst,
  input  logic [2*W-1:0]  in_kind,
  input  logic [FW-1:0]   tok_free,
  input  logic [FW-1:0]   preg_free,
  input  logic [SPW-1:0]  sched_space,
  input  logic [SPW-1:0]  lq_space,
  input  logic [SPW-1:0]  sq_space,
  output logic [W-1:0]    take,
  output stall_cause_e    cause,
  output logic [FW-1:0]   grp_uops,
  output logic [FW-1:0]   grp_dst
);
  logic [FW-1:0] acc_l, acc_s;
  logic [FW-1:0] nu, nd, nl, ns;
  logic          stop;

  always_comb begin
    take     = '0;
    cause    = CAUSE_NONE;
    grp_uops = '0;
    grp_dst  = '0;
    acc_l    = '0;
    acc_s    = '0;
    stop     = 1'b0;
    nu = '0; nd = '0; nl = '0; ns = '0;
    for (int i = 0; i < W; i++) begin
      nu = grp_uops + FW'(in_uops[i*UW +: UW]);
      nd = grp_dst + FW'(in_ndst[i*DW +: DW]);
      nl = acc_l + FW'(in_kind[i*2 +: 2] == KIND_LOAD);
      ns = acc_s + FW'(in_kind[i*2 +: 2] == KIND_STORE);
      if (!stop) begin
        if (!in_valid[i] || nu > FW'(W)) begin
          stop = 1'b1;
        end else if (!UNLIM && nd > preg_free) begin
          stop = 1'b1; cause = CAUSE_REG;
        end else if (nu > tok_free) begin
          stop = 1'b1; cause = CAUSE_TOK;
        end else if (nu > FW'(sched_space)) begin
          stop = 1'b1; cause = CAUSE_SCHED;
        end else if (nl > FW'(lq_space)) begin
          stop = 1'b1; cause = CAUSE_LQ;
        end else if (ns > FW'(sq_space)) begin
          stop = 1'b1; cause = CAUSE_SQ;
        end else begin
          take[i]  = 1'b1;
          grp_uops = nu;
          grp_dst  = nd;
          acc_l    = nl;
          acc_s    = ns;
        end
      end
    end
  end
endmodule

// File: rtl/credit_pool.sv
module credit_pool #(
  parameter int TOTAL = 8,
  parameter int FW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] take_amt,
  input  logic [FW-1:0] give_amt,
  output logic [FW-1:0] free_cnt
);
  logic [FW-1:0] free_q, free_d;
  logic          upd_en;

  always_comb begin
    upd_en = (take_amt != '0) || (give_amt != '0);
    free_d = free_q - take_amt + give_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      free_q <= FW'(TOTAL);
    else if (upd_en) free_q <= free_d;
  end

  assign free_cnt = free_q;
endmodule

// File: rtl/rob_ring.sv
module rob_ring #(
  parameter int DEPTH = 8,
  parameter int TW    = 3,
  parameter int W     = 2,
  parameter int UW    = 2,
  parameter int DW    = 2,
  parameter int FW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  alloc,
  input  logic [W*UW-1:0] alloc_uops,
  input  logic [W*DW-1:0] alloc_ndst,
  input  logic [W-1:0]  wb_valid,
  input  logic [W*TW-1:0] wb_tag,
  output logic [TW-1:0] tail_ptr,
  output logic [W-1:0]  ret_valid,
  output logic [W*TW-1:0] ret_tag,
  output logic [FW-1:0] ret_uops,
  output logic [FW-1:0] ret_dst,
  output logic          empty,
  output logic          full
);
  logic [TW-1:0]    head_q, head_d, tail_q, tail_d, idx;
  logic [TW:0]      cnt_q, cnt_d, n_ret, n_alloc;
  logic [DEPTH-1:0] done_q, done_d;
  logic             go, st_en;
  logic [UW-1:0]    uops_mem [DEPTH];
  logic [DW-1:0]    dst_mem  [DEPTH];

  // in-order retire scan from the head
  always_comb begin
    ret_valid = '0;
    ret_tag   = '0;
    ret_uops  = '0;
    ret_dst   = '0;
    n_ret     = '0;
    go        = 1'b1;
    idx       = head_q;
    for (int j = 0; j < W; j++) begin
      idx = head_q + TW'(j);
      ret_tag[j*TW +: TW] = idx;
      if (go && ((TW+1)'(j) < cnt_q) && done_q[idx]) begin
        ret_valid[j] = 1'b1;
        ret_uops     = ret_uops + FW'(uops_mem[idx]);
        ret_dst      = ret_dst + FW'(dst_mem[idx]);
        n_ret        = n_ret + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end

  always_comb begin
    n_alloc = '0;
    for (int j = 0; j < W; j++) n_alloc = n_alloc + (TW+1)'(alloc[j]);
    done_d = done_q;
    for (int j = 0; j < W; j++)
      if (wb_valid[j]) done_d[wb_tag[j*TW +: TW]] = 1'b1;
    for (int j = 0; j < W; j++)
      if (ret_valid[j]) done_d[head_q + TW'(j)] = 1'b0;
    for (int j = 0; j < W; j++)
      if (alloc[j]) done_d[tail_q + TW'(j)] = 1'b0;
    head_d = head_q + TW'(n_ret);
    tail_d = tail_q + TW'(n_alloc);
    cnt_d  = cnt_q + n_alloc - n_ret;
    st_en  = (|alloc) || (|ret_valid) || (|wb_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else if (st_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // payload needs no reset: read only for occupied slots
  always_ff @(posedge clk) begin
    for (int j = 0; j < W; j++) begin
      if (alloc[j]) begin
        uops_mem[tail_q + TW'(j)] <= alloc_uops[j*UW +: UW];
        dst_mem[tail_q + TW'(j)]  <= alloc_ndst[j*DW +: DW];
      end
    end
  end

  assign tail_ptr = tail_q;
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == (TW+1)'(DEPTH));
endmodule

// File: rtl/perf_counters.sv
module perf_counters
  import disp_pkg::*;
#(
  parameter int W  = 2,
  parameter int CW = 16,
  parameter int FW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FW-1:0]            disp_n,
  input  logic [W-1:0]             ret_valid,
  input  stall_cause_e             cause,
  output logic [(W+1)*CW-1:0]      disp_hist,
  output logic [(W+1)*CW-1:0]      ret_hist,
  output logic [NUM_CAUSES*CW-1:0] stall_cnt
);
  logic [FW-1:0] ret_n;

  always_comb begin
    ret_n = '0;
    for (int j = 0; j < W; j++) ret_n = ret_n + FW'(ret_valid[j]);
  end

  for (genvar k = 0; k <= W; k++) begin : g_bin
    logic [CW-1:0] dq, rq;
    logic          den, ren;
    assign den = (disp_n == FW'(k));
    assign ren = (ret_n == FW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dq <= '0;
      else if (den) dq <= dq + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rq <= '0;
      else if (ren) rq <= rq + 1'b1;
    end
    assign disp_hist[k*CW +: CW] = dq;
    assign ret_hist[k*CW +: CW]  = rq;
  end

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
    logic [CW-1:0] sq;
    logic          sen;
    assign sen = (3'(cause) == 3'(c + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sq <= '0;
      else if (sen) sq <= sq + 1'b1;
    end
    assign stall_cnt[c*CW +: CW] = sq;
  end
endmodule

// File: rtl/dispatch_retire_ctl.sv
module dispatch_retire_ctl
  import disp_pkg::*;
#(
  parameter int W           = 2,
  parameter int ROB_ENTRIES = 8,
  parameter int PREGS       = 6,
  parameter int UW          = 2,
  parameter int DW          = 2,
  parameter int SPW         = 4,
  parameter int CW          = 16,
  localparam int TW         = $clog2(ROB_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             in_valid,
  input  logic [W*UW-1:0]          in_uops,
  input  logic [W*DW-1:0]          in_ndst,
  input  logic [2*W-1:0]           in_kind,
  input  logic [SPW-1:0]           sched_space,
  input  logic [SPW-1:0]           lq_space,
  input  logic [SPW-1:0]           sq_space,
  output logic [W-1:0]             disp_valid,
  output logic [W*TW-1:0]          disp_tag,
  input  logic [W-1:0]             wb_valid,
  input  logic [W*TW-1:0]          wb_tag,
  output logic [W-1:0]             ret_valid,
  output logic [W*TW-1:0]          ret_tag,
  output logic [(W+1)*CW-1:0]      disp_hist,
  output logic [(W+1)*CW-1:0]      ret_hist,
  output logic [NUM_CAUSES*CW-1:0] stall_cnt
);
  localparam int FW = $clog2(ROB_ENTRIES + PREGS + 4*W + 1) + 1;

  logic [FW-1:0] tok_free, preg_free, grp_uops, grp_dst, ret_uops, ret_dst;
  logic [TW-1:0] tail_ptr;
  logic [W-1:0]  take;
  logic          rob_empty, rob_full;
  stall_cause_e  cause;

  dispatch_select #(
    .W(W), .UW(UW), .DW(DW), .SPW(SPW), .FW(FW), .UNLIM(PREGS == 0)
  ) u_sel (
    .in_valid(in_valid), .in_uops(in_uops), .in_ndst(in_ndst), .in_kind(in_kind),
    .tok_free(tok_free), .preg_free(preg_free),
    .sched_space(sched_space), .lq_space(lq_space), .sq_space(sq_space),
    .take(take), .cause(cause), .grp_uops(grp_uops), .grp_dst(grp_dst)
  );

  rob_ring #(
    .DEPTH(ROB_ENTRIES), .TW(TW), .W(W), .UW(UW), .DW(DW), .FW(FW)
  ) u_rob (
    .clk(clk), .rst_n(rst_n), .alloc(take), .alloc_uops(in_uops), .alloc_ndst(in_ndst),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .tail_ptr(tail_ptr),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_uops(ret_uops), .ret_dst(ret_dst),
    .empty(rob_empty), .full(rob_full)
  );

  credit_pool #(.TOTAL(ROB_ENTRIES), .FW(FW)) u_tok (
    .clk(clk), .rst_n(rst_n), .take_amt(grp_uops), .give_amt(ret_uops), .free_cnt(tok_free)
  );

  if (PREGS == 0) begin : g_unlim
    assign preg_free = '1;
  end else begin : g_pool
    credit_pool #(.TOTAL(PREGS), .FW(FW)) u_preg (
      .clk(clk), .rst_n(rst_n), .take_amt(grp_dst), .give_amt(ret_dst), .free_cnt(preg_free)
    );
  end

  perf_counters #(.W(W), .CW(CW), .FW(FW)) u_perf (
    .clk(clk), .rst_n(rst_n), .disp_n(grp_uops), .ret_valid(ret_valid), .cause(cause),
    .disp_hist(disp_hist), .ret_hist(ret_hist), .stall_cnt(stall_cnt)
  );

  assign disp_valid = take;
  always_comb begin
    for (int j = 0; j < W; j++) disp_tag[j*TW +: TW] = tail_ptr + TW'(j);
  end
endmodule

// File: rtl/dispatch_retire_chk.sv
module dispatch_retire_chk #(
  parameter int W           = 2,
  parameter int ROB_ENTRIES = 8,
  parameter int PREGS       = 6,
  parameter int CW          = 16,
  parameter int NC          = 5,
  parameter int FW          = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     in_valid,
  input logic [W-1:0]     disp_valid,
  input logic [W-1:0]     ret_valid,
  input logic [NC*CW-1:0] stall_cnt,
  input logic [FW-1:0]    tok_free,
  input logic [FW-1:0]    preg_free,
  input logic             rob_empty,
  input logic             rob_full
);
  logic [W-1:0] disp_inc, ret_inc;
  assign disp_inc = disp_valid + W'(1);
  assign ret_inc  = ret_valid + W'(1);

  // R1
  disp_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_valid & ~in_valid) == '0) && ((disp_valid & disp_inc) == '0));

  // R6
  ret_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid & ret_inc) == '0);

  // R6
  ret_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ret_valid) |-> !rob_empty);

  // R3
  tok_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_free <= FW'(ROB_ENTRIES));

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> (disp_valid == '0));

  if (PREGS > 0) begin : g_preg
    // R4
    preg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preg_free <= FW'(PREGS));
  end

  for (genvar k = 0; k < NC; k++) begin : g_step
    // R8
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_cnt[k*CW +: CW] - $past(stall_cnt[k*CW +: CW])) <= CW'(1));
  end
endmodule

bind dispatch_retire_ctl dispatch_retire_chk #(
  .W(W), .ROB_ENTRIES(ROB_ENTRIES), .PREGS(PREGS), .CW(CW), .NC(disp_pkg::NUM_CAUSES), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_valid(disp_valid),
  .ret_valid(ret_valid), .stall_cnt(stall_cnt), .tok_free(tok_free),
  .preg_free(preg_free), .rob_empty(rob_empty), .rob_full(rob_full)
);

// File: tb/dispatch_retire_ctl_tb.sv
module dispatch_retire_ctl_tb;
  localparam int W = 2, ROB = 8, UW = 2, DW = 2, SPW = 4, CW = 16, TW = 3, NC = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] in_valid, wb_valid;
  logic [W*UW-1:0] in_uops;
  logic [W*DW-1:0] in_ndst;
  logic [2*W-1:0] in_kind;
  logic [SPW-1:0] sched_space, lq_space, sq_space;
  logic [W*TW-1:0] wb_tag;
  logic [W-1:0] disp_valid, ret_valid, u_disp_valid, u_ret_valid;
  logic [W*TW-1:0] disp_tag, ret_tag, u_disp_tag, u_ret_tag;
  logic [(W+1)*CW-1:0] disp_hist, ret_hist, u_disp_hist, u_ret_hist;
  logic [NC*CW-1:0] stall_cnt, u_stall_cnt;

  int n_checks = 0;
  int n_errs = 0;

  always #4 clk = ~clk;

  dispatch_retire_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_ndst(in_ndst),
    .in_kind(in_kind), .sched_space(sched_space), .lq_space(lq_space), .sq_space(sq_space),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .disp_hist(disp_hist), .ret_hist(ret_hist),
    .stall_cnt(stall_cnt));

  dispatch_retire_ctl #(.PREGS(0)) u_unl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops), .in_ndst(in_ndst),
    .in_kind(in_kind), .sched_space(sched_space), .lq_space(lq_space), .sq_space(sq_space),
    .disp_valid(u_disp_valid), .disp_tag(u_disp_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .ret_valid(u_ret_valid), .ret_tag(u_ret_tag), .disp_hist(u_disp_hist), .ret_hist(u_ret_hist),
    .stall_cnt(u_stall_cnt));

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stl(int k); return int'(stall_cnt[k*CW +: CW]); endfunction
  function automatic int dh(int k);  return int'(disp_hist[k*CW +: CW]); endfunction
  function automatic int rh(int k);  return int'(ret_hist[k*CW +: CW]); endfunction
  function automatic int dtag(int j); return int'(disp_tag[j*TW +: TW]); endfunction
  function automatic int rtag(int j); return int'(ret_tag[j*TW +: TW]); endfunction

  task automatic idle();
    in_valid = '0; in_uops = '0; in_ndst = '0; in_kind = '0;
    wb_valid = '0; wb_tag = '0;
    sched_space = 4'd8; lq_space = 4'd4; sq_space = 4'd4;
  endtask

  task automatic lane(int i, int uops, int ndst, int kind);
    in_valid[i] = 1'b1;
    in_uops[i*UW +: UW] = UW'(uops);
    in_ndst[i*DW +: DW] = DW'(ndst);
    in_kind[i*2 +: 2] = 2'(kind);
  endtask

  task automatic wb(int j, int t);
    wb_valid[j] = 1'b1;
    wb_tag[j*TW +: TW] = TW'(t);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    int s;
    do_reset();
    #1;
    s = 0;
    for (int k = 0; k < NC; k++) s += stl(k);
    check("R10 stall counters clear", s, 0);
    s = 0;
    for (int k = 0; k <= W; k++) s += dh(k) + rh(k);
    check("R10 histograms clear", s, 0);
    check("R10 no retire", int'(ret_valid), 0);
    idle(); lane(0, 1, 1, 0); lane(1, 1, 1, 0);
    #1;
    check("R11 first tag", dtag(0), 0);
    check("R11 second tag", dtag(1), 1);
    tick(); idle();
  endtask

  task automatic t_basic();
    int snap;
    do_reset();
    snap = dh(2);
    idle(); lane(0, 1, 1, 0); lane(1, 1, 1, 0);
    #1;
    check("R1 both lanes admitted", int'(disp_valid), 3);
    tick(); idle();
    check("R9 two-uop bin", dh(2), snap + 1);
    snap = dh(0);
    #1; tick();
    check("R9 idle bin", dh(0), snap + 1);
    lane(0, 1, 0, 0);
    #1;
    check("R11 consecutive tag", dtag(0), 2);
    tick(); idle();
  endtask

  task automatic t_width();
    int s;
    do_reset();
    idle(); lane(0, 2, 0, 0); lane(1, 1, 0, 0);
    #1;
    check("R2 width limit", int'(disp_valid), 1);
    tick(); idle();
    s = 0;
    for (int k = 0; k < NC; k++) s += stl(k);
    check("R2 width stop not charged", s, 0);
  endtask

  task automatic t_stop();
    do_reset();
    idle(); lq_space = 4'd0; lane(0, 1, 0, 1); lane(1, 1, 0, 0);
    #1;
    check("R1 blocked oldest stops younger", int'(disp_valid), 0);
    tick();
    check("R5 load queue stall", stl(3), 1);
    idle(); lane(1, 1, 0, 0);
    #1;
    check("R1 invalid oldest stops younger", int'(disp_valid), 0);
    tick();
    check("R8 gap not charged", stl(3) + stl(0) + stl(1) + stl(2) + stl(4), 1);
    idle();
  endtask

  task automatic t_space();
    do_reset();
    idle(); sched_space = 4'd1; lane(0, 1, 0, 0); lane(1, 1, 0, 0);
    #1;
    check("R5 scheduler space", int'(disp_valid), 1);
    tick();
    check("R5 scheduler stall", stl(2), 1);
    idle(); sq_space = 4'd1; lane(0, 1, 0, 2); lane(1, 1, 0, 2);
    #1;
    check("R5 store queue space", int'(disp_valid), 1);
    tick();
    check("R5 store queue stall", stl(4), 1);
    idle();
  endtask

  task automatic t_regs();
    int snap;
    do_reset();
    idle(); lane(0, 1, 3, 0); lane(1, 1, 3, 0);
    #1;
    check("R4 pool covers both", int'(disp_valid), 3);
    tick();
    idle(); lane(0, 1, 1, 0); sched_space = 4'd0;
    #1;
    check("R4 pool drained", int'(disp_valid), 0);
    tick();
    check("R8 register cause", stl(0), 1);
    check("R8 priority over scheduler", stl(2), 0);
    idle(); lane(0, 1, 1, 0); wb(0, 1);
    #1; tick();
    idle(); lane(0, 1, 1, 0); wb(0, 0);
    #1;
    check("R6 younger waits for older", int'(ret_valid), 0);
    tick();
    idle(); lane(0, 1, 1, 0);
    snap = rh(2);
    #1;
    check("R6 two retire", int'(ret_valid), 3);
    check("R6 oldest tag", rtag(0), 0);
    check("R6 next tag", rtag(1), 1);
    check("R7 not yet returned", int'(disp_valid), 0);
    tick();
    check("R9 retire bin", rh(2), snap + 1);
    check("R8 register stall count", stl(0), 4);
    idle(); lane(0, 1, 1, 0);
    #1;
    check("R7 registers returned", int'(disp_valid), 1);
    check("R11 tag after retire", dtag(0), 2);
    tick(); idle();
  endtask

  task automatic t_tokens();
    do_reset();
    for (int c = 0; c < 4; c++) begin
      idle(); lane(0, 2, 0, 0);
      #1;
      check("R3 entries available", int'(disp_valid), 1);
      check("R11 tag sequence", dtag(0), c);
      tick();
    end
    idle(); lane(0, 1, 0, 0); wb(0, 0);
    #1;
    check("R3 entries exhausted", int'(disp_valid), 0);
    tick();
    check("R8 token cause", stl(1), 1);
    idle(); lane(0, 1, 0, 0);
    #1;
    check("R6 single retire", int'(ret_valid), 1);
    check("R6 retire tag", rtag(0), 0);
    check("R7 entries not yet back", int'(disp_valid), 0);
    tick();
    check("R8 token count", stl(1), 2);
    idle(); lane(0, 1, 0, 0);
    #1;
    check("R7 entries back", int'(disp_valid), 1);
    check("R11 tag after wait", dtag(0), 4);
    tick(); idle();
  endtask

  task automatic t_unlim();
    do_reset();
    for (int c = 0; c < 3; c++) begin
      idle(); lane(0, 1, 3, 0);
      #1;
      check("R4 unlimited pool admits", int'(u_disp_valid), 1);
      check("R4 limited pool", int'(disp_valid), (c < 2) ? 1 : 0);
      tick();
    end
    idle();
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    t_reset();
    t_basic();
    t_width();
    t_stop();
    t_space();
    t_regs();
    t_tokens();
    t_unlim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule